// File: doc/BRIEF.md
# Stepped Volume Attenuation Controller

This block is the digital control core of a two-channel stepped audio attenuator. It stores an attenuation setting as an index from 0 to 34. Each index step is worth 2 dB, so the range runs from 0 dB down to -68 dB. A debounced key drives the block. While the key is held, each rising edge of an external oscillator tick moves the setting by one step. A direction input picks the way it moves. The setting stops at either end and never wraps.

The stored index is split into two one-hot tap selects, and both audio channels use them in the same way. The coarse select has seven taps worth 10 dB each. The fine select has five taps worth 2 dB each. The total attenuation is the coarse tap plus the fine tap.

Reset puts the setting at -40 dB. A supply-good input that drops forces the setting back to -40 dB. An active-low inhibit input blanks both selects and holds the setting. All asynchronous inputs pass through a two-flop synchroniser. The selects are registered so that they never glitch.

Top module: `step_atten_ctrl`

## Requirements
- R1: After reset, levelIdx is 20, coarseSel is 7'b0010000 (bit 4) and fineSel is 5'b00001 (bit 0).
- R2: While keyActive is high and dirUp is high (1), each rising edge of oscTick lowers levelIdx by one, which is 2 dB less attenuation.
- R3: While keyActive is high and dirUp is low (0), each rising edge of oscTick raises levelIdx by one, which is 2 dB more attenuation.
- R4: levelIdx stays within 0 to 34. A further step past either end leaves it unchanged.
- R5: When the selects are enabled, coarseSel has exactly bit (levelIdx / 5) set. Bit 0 is 0 dB and bit 6 is -60 dB.
- R6: When the selects are enabled, fineSel has exactly bit (levelIdx mod 5) set. Bit 0 is 0 dB and bit 4 is -8 dB.
- R7: A step happens only on a rising edge of oscTick while keyActive is high. A tick that is held high gives a single step, and ticks while keyActive is low change nothing.
- R8: While supplyOk is low (0), levelIdx is forced to 20, and ticks do not move it. Once supplyOk returns high, the selects decode index 20.
- R9: While inhibitN is low (0), coarseSel and fineSel are all zero, levelIdx holds its value and ticks are ignored. Once inhibitN is released, the selects decode the held index again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| oscTick | input | 1 | Step oscillator tick, asynchronous |
| keyActive | input | 1 | Key held, enables stepping, asynchronous |
| dirUp | input | 1 | 1 = less attenuation, 0 = more, asynchronous |
| supplyOk | input | 1 | Supply above threshold; low forces -40 dB, asynchronous |
| inhibitN | input | 1 | Active-low inhibit, blanks selects and freezes setting |
| coarseSel | output | 7 | One-hot 10 dB tap select |
| fineSel | output | 5 | One-hot 2 dB tap select |
| levelIdx | output | 6 | Current setting, 2 dB per count |

## Verification
The bench drives the setting past both ends and expects it to stay at 0 and at 34. A counter that wraps would jump to the far end of the range. The bench holds the tick high for several cycles to catch level-sensitive stepping, which would run away by many steps. It also pulses the tick with the key released, where a design that ignored the key would drift. Inhibit and supply drop are each applied while ticks arrive. A design that let inhibit leak into the stored index, or that let undervoltage lose to a step, would show a wrong index or nonzero selects. Decode is checked at indices that fall on and between the 10 dB boundaries, where an off-by-one in the divide or the modulo shows up.

// File: rtl/atten_pkg.sv
package atten_pkg;
  // Per-cycle command from control to datapath
  typedef struct packed {
    logic incr;    // one step more attenuation
    logic decr;    // one step less attenuation
    logic reinit;  // force the initial setting
    logic outEn;   // selects enabled
  } stepCmd_t;
endpackage

// File: rtl/sync_bus.sv
module sync_bus #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= RESET_VAL;
      else if (s == 0) stageQ[s] <= asyncIn;
      else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
  import atten_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     oscTick,
  input  logic     keyActive,
  input  logic     dirUp,
  input  logic     supplyOk,
  input  logic     inhibitN,
  output stepCmd_t cmd
);
  localparam int N_IN = 5;
  // bit order: {supplyOk, inhibitN, dirUp, keyActive, oscTick}
  localparam logic [N_IN-1:0] IDLE_VAL = 5'b11000;

  logic [N_IN-1:0] rawIn, syncIn;
  logic tickS, keyS, dirS, inhS, okS;
  logic tickPrev, tickRise, stepOk;

  assign rawIn = {supplyOk, inhibitN, dirUp, keyActive, oscTick};

  sync_bus #(
    .WIDTH(N_IN), .STAGES(SYNC_STAGES), .RESET_VAL(IDLE_VAL)
  ) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(syncIn)
  );

  assign {okS, inhS, dirS, keyS, tickS} = syncIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickPrev <= 1'b0;
    else tickPrev <= tickS;
  end

  assign tickRise = tickS & ~tickPrev;
  assign stepOk   = tickRise & keyS & inhS & okS;

  always_comb begin
    cmd.incr   = stepOk & ~dirS;
    cmd.decr   = stepOk & dirS;
    cmd.reinit = ~okS;
    cmd.outEn  = inhS;
  end
endmodule

// File: rtl/atten_datapath.sv
module atten_datapath
  import atten_pkg::*;
#(
  parameter int FINE_TAPS = 5,
  parameter int COARSE_TAPS = 7,
  parameter int INIT_IDX = 20,
  localparam int NUM_STEPS = FINE_TAPS * COARSE_TAPS,
  localparam int IDX_W = $clog2(NUM_STEPS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  stepCmd_t               cmd,
  output logic [COARSE_TAPS-1:0] coarseSel,
  output logic [FINE_TAPS-1:0]   fineSel,
  output logic [IDX_W-1:0]       levelIdx
);
  localparam logic [IDX_W-1:0] MAX_IDX  = IDX_W'(NUM_STEPS - 1);
  localparam logic [IDX_W-1:0] INIT_VAL = IDX_W'(INIT_IDX);
  localparam int INIT_COARSE = INIT_IDX / FINE_TAPS;
  localparam int INIT_FINE   = INIT_IDX % FINE_TAPS;

  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] fineVal;
  logic [COARSE_TAPS-1:0] coarseNext, coarseQ;
  logic [FINE_TAPS-1:0]   fineNext, fineQ;

  // Saturating step counter; undervoltage wins over a step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idxQ <= INIT_VAL;
    else if (cmd.reinit) idxQ <= INIT_VAL;
    else if (cmd.incr && idxQ != MAX_IDX) idxQ <= idxQ + 1'b1;
    else if (cmd.decr && idxQ != '0) idxQ <= idxQ - 1'b1;
  end

  assign fineVal = idxQ % IDX_W'(FINE_TAPS);

  for (genvar c = 0; c < COARSE_TAPS; c++) begin : g_coarse
    assign coarseNext[c] = (idxQ >= IDX_W'(c * FINE_TAPS)) &&
                           (idxQ <  IDX_W'((c + 1) * FINE_TAPS));
  end

  for (genvar f = 0; f < FINE_TAPS; f++) begin : g_fine
    assign fineNext[f] = (fineVal == IDX_W'(f));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coarseQ <= COARSE_TAPS'(1) << INIT_COARSE;
      fineQ   <= FINE_TAPS'(1) << INIT_FINE;
    end else if (cmd.outEn) begin
      coarseQ <= coarseNext;
      fineQ   <= fineNext;
    end else begin
      coarseQ <= '0;
      fineQ   <= '0;
    end
  end

  assign coarseSel = coarseQ;
  assign fineSel   = fineQ;
  assign levelIdx  = idxQ;
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import atten_pkg::*;
#(
  parameter int FINE_TAPS = 5,
  parameter int COARSE_TAPS = 7,
  parameter int INIT_IDX = 20,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(FINE_TAPS * COARSE_TAPS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   oscTick,
  input  logic                   keyActive,
  input  logic                   dirUp,
  input  logic                   supplyOk,
  input  logic                   inhibitN,
  output logic [COARSE_TAPS-1:0] coarseSel,
  output logic [FINE_TAPS-1:0]   fineSel,
  output logic [IDX_W-1:0]       levelIdx
);
  stepCmd_t cmd;

  atten_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .keyActive(keyActive),
    .dirUp(dirUp), .supplyOk(supplyOk), .inhibitN(inhibitN), .cmd(cmd)
  );

  atten_datapath #(
    .FINE_TAPS(FINE_TAPS), .COARSE_TAPS(COARSE_TAPS), .INIT_IDX(INIT_IDX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .coarseSel(coarseSel), .fineSel(fineSel), .levelIdx(levelIdx)
  );
endmodule

// File: rtl/step_atten_chk.sv
module step_atten_chk #(
  parameter int FINE_TAPS = 5,
  parameter int COARSE_TAPS = 7,
  parameter int INIT_IDX = 20,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(FINE_TAPS * COARSE_TAPS),
  localparam int LAT = SYNC_STAGES + 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   supplyOk,
  input logic                   inhibitN,
  input logic [COARSE_TAPS-1:0] coarseSel,
  input logic [FINE_TAPS-1:0]   fineSel,
  input logic [IDX_W-1:0]       levelIdx
);
  localparam logic [IDX_W-1:0] INIT_VAL = IDX_W'(INIT_IDX);
  localparam logic [IDX_W-1:0] MAX_IDX  = IDX_W'(FINE_TAPS * COARSE_TAPS - 1);

  logic [IDX_W-1:0] prevIdx;
  logic [LAT-1:0]   okHist, inhHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIdx <= INIT_VAL;
      okHist  <= '1;
      inhHist <= '1;
    end else begin
      prevIdx <= levelIdx;
      okHist  <= {okHist[LAT-2:0], supplyOk};
      inhHist <= {inhHist[LAT-2:0], inhibitN};
    end
  end

  p_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    levelIdx <= MAX_IDX);

  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (levelIdx == prevIdx) || (levelIdx == prevIdx + 1'b1) ||
    (levelIdx + 1'b1 == prevIdx) || (levelIdx == INIT_VAL));

  p_coarse_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(coarseSel) && $onehot0(fineSel));

  p_coarse_decode_r5: assert property (@(posedge clk) disable iff (!rstN)
    (coarseSel != '0) |->
      coarseSel == (COARSE_TAPS'(1) << (prevIdx / IDX_W'(FINE_TAPS))));

  p_fine_decode_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fineSel != '0) |->
      fineSel == (FINE_TAPS'(1) << (prevIdx % IDX_W'(FINE_TAPS))));

  p_reinit_r8: assert property (@(posedge clk) disable iff (!rstN)
    !okHist[LAT-1] |-> levelIdx == INIT_VAL);

  p_blank_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inhHist[LAT-1] |-> (coarseSel == '0 && fineSel == '0));
endmodule

bind step_atten_ctrl step_atten_chk #(
  .FINE_TAPS(FINE_TAPS), .COARSE_TAPS(COARSE_TAPS),
  .INIT_IDX(INIT_IDX), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .inhibitN(inhibitN),
  .coarseSel(coarseSel), .fineSel(fineSel), .levelIdx(levelIdx)
);

// File: tb/test_step_atten_ctrl.sv
module test_step_atten_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscTick = 1'b0, keyActive = 1'b0, dirUp = 1'b0;
  logic supplyOk = 1'b1, inhibitN = 1'b1;
  logic [6:0] coarseSel;
  logic [4:0] fineSel;
  logic [5:0] levelIdx;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  step_atten_ctrl i_step_atten_ctrl (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .keyActive(keyActive),
    .dirUp(dirUp), .supplyOk(supplyOk), .inhibitN(inhibitN),
    .coarseSel(coarseSel), .fineSel(fineSel), .levelIdx(levelIdx)
  );

  // Vector table: direction (1 = up), tick count, expected index
  localparam int NV = 7;
  localparam int vDir [NV] = '{1, 0, 1, 0, 0, 1, 0};
  localparam int vCnt [NV] = '{3, 5, 25, 10, 30, 1, 2};
  localparam int vExp [NV] = '{17, 22, 0, 10, 34, 33, 34};

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkLevel(input string tag, input int exp);
    check({tag, " R5 coarse"}, int'(coarseSel), 1 << (exp / 5));
    check({tag, " R6 fine"}, int'(fineSel), 1 << (exp % 5));
    check({tag, " index"}, int'(levelIdx), exp);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic ticks(input bit up, input bit key, input int n);
    dirUp = up;
    keyActive = key;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      oscTick = 1'b1;
      repeat (5) @(negedge clk);   // held high: one step only (R7)
      oscTick = 1'b0;
      repeat (3) @(negedge clk);
    end
    settle();
    keyActive = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkLevel("R1 reset", 20);

    // R2 R3 R4 walk through the table
    for (int v = 0; v < NV; v++) begin
      ticks(vDir[v] != 0, 1'b1, vCnt[v]);
      checkLevel("R2 R3 R4 vector", vExp[v]);
    end

    // back off the bottom limit to a boundary-adjacent index
    ticks(1'b1, 1'b1, 5);
    checkLevel("R5 R6 boundary", 29);

    // R7: ticks with key released do nothing
    ticks(1'b0, 1'b0, 3);
    checkLevel("R7 key idle", 29);

    // R9: inhibit blanks selects and freezes the index
    inhibitN = 1'b0;
    settle();
    check("R9 coarse blank", int'(coarseSel), 0);
    check("R9 fine blank", int'(fineSel), 0);
    ticks(1'b1, 1'b1, 3);
    check("R9 index held", int'(levelIdx), 29);
    check("R9 still blank", int'(coarseSel) + int'(fineSel), 0);
    inhibitN = 1'b1;
    settle();
    checkLevel("R9 release", 29);

    // R8: supply drop forces index 20, ticks ignored meanwhile
    supplyOk = 1'b0;
    settle();
    check("R8 reinit", int'(levelIdx), 20);
    ticks(1'b0, 1'b1, 2);
    check("R8 held during drop", int'(levelIdx), 20);
    supplyOk = 1'b1;
    settle();
    checkLevel("R8 recovered", 20);

    // R8 with inhibit: reinit still applies, selects stay blank
    ticks(1'b1, 1'b1, 4);
    checkLevel("R2 after recovery", 16);
    inhibitN = 1'b0;
    supplyOk = 1'b0;
    settle();
    check("R8 reinit under inhibit", int'(levelIdx), 20);
    check("R9 blank under drop", int'(fineSel), 0);
    supplyOk = 1'b1;
    inhibitN = 1'b1;
    settle();
    checkLevel("R8 R9 both released", 20);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule